// File: doc/BRIEF.md
# Threshold adjustment command detector

This block sits beside a mode-0 serial slave port and looks for the two-frame command that moves a supply trip threshold. Each frame is 24 serial bits framed by chip select: one command byte and then a 16-bit value. When the first frame carries the arm pattern and the second frame carries either the raise pattern or the clear pattern, the block issues a single-cycle strobe. A raise strobe tells the analog side to program the threshold at the present supply level. A clear strobe returns the threshold to its native low level.

All inputs are already synchronous to the system clock. The serial clock and chip select are edge-detected in that domain. A program-enable level, standing in for the high-voltage enable pin, must stay high for the whole command. After each accepted command, a busy flag covers the self-timed programming window. A recovery window follows it, and the block discards any command that falls inside either window. Both windows are counted in pulses of an external tick, for example 1 ms pulses, so the defaults give 10 ms each.

Top module: `trip_prog_detect`

## Requirements
- R1: After reset, `thr_raise`, `thr_clear` and `busy` are low and the detector is idle.
- R2: A first frame of 24'h030001, a chip-select deassertion, and then a second frame of 24'h020001 produce exactly one `thr_raise` pulse. The pulse is high in the second clock cycle after the first rising clock edge that samples `cs_n` high at the end of the second frame.
- R3: The same sequence with a second frame of 24'h020003 produces exactly one `thr_clear` pulse, with the same timing as R2.
- R4: `sdi` is sampled on rising edges of `sck` while `cs_n` is low, MSB first. A frame counts only if it held exactly 24 such edges. A frame with more or fewer edges is discarded, and the detector returns to idle.
- R5: A frame with any byte different from the expected one is discarded and returns the detector to idle. A raise or clear frame that does not follow an accepted arm frame produces no strobe.
- R6: `prog_en` low in any cycle returns the detector to idle. A frame that ends while `prog_en` is low is discarded, so a drop between the two frames cancels the command.
- R7: `thr_raise` and `thr_clear` are never high together, and each pulse lasts exactly one clock cycle.
- R8: `busy` rises in the cycle after a strobe. It stays high until BUSY_TICKS `tick` pulses have been seen while it is high, and falls after the last of them.
- R9: Frames that end while `busy` is high, or within RECOV_TICKS `tick` pulses after `busy` falls, are discarded. Once that window has passed, a command is accepted again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Synchronised chip select, active low |
| sck | input | 1 | Synchronised serial clock, mode 0 |
| sdi | input | 1 | Synchronised serial data in |
| prog_en | input | 1 | Programming enable qualifier |
| tick | input | 1 | Timebase pulse, one clock wide |
| thr_raise | output | 1 | One-cycle strobe: program the threshold upward |
| thr_clear | output | 1 | One-cycle strobe: return the threshold to its native level |
| busy | output | 1 | Programming window in progress |

## Verification
Two register stages separate the clock edge that first samples `cs_n` high from a strobe. One stage captures the finished frame and the next registers the decision. The strobe is therefore due two edges later, and `busy` is due one edge after the strobe. The bench drives inputs on falling clock edges and samples on falling edges. The directed timing test checks the strobe low, high and low again on three consecutive falling edges after chip select rises. Strobe counts for the table vectors are taken from a falling-edge monitor a few cycles after each command, so phase cannot hide a missing or extra pulse. The `busy` width is checked by counting the tick pulses that the bench issues while `busy` reads high.

// File: rtl/trip_seq_pkg.sv
package trip_seq_pkg;

    localparam int FRAME_BITS = 24;
    localparam int CNT_W      = $clog2(FRAME_BITS + 2);
    localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FRAME_BITS + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);

    localparam logic [FRAME_BITS-1:0] ARM_WORD   = 24'h030001;
    localparam logic [FRAME_BITS-1:0] RAISE_WORD = 24'h020001;
    localparam logic [FRAME_BITS-1:0] CLEAR_WORD = 24'h020003;

    typedef struct packed {
        logic [FRAME_BITS-1:0] word;
        logic                  len_ok;
    } frame_t;

    typedef enum logic {
        SQ_IDLE,
        SQ_ARMED
    } seq_state_e;

    typedef enum logic [1:0] {
        TM_IDLE,
        TM_BUSY,
        TM_RECOV
    } tmr_state_e;

    typedef enum logic [1:0] {
        CMD_NONE,
        CMD_ARM,
        CMD_RAISE,
        CMD_CLEAR
    } cmd_e;

    function automatic cmd_e classify(input frame_t f);
        cmd_e c;
        c = CMD_NONE;
        if (f.len_ok) begin
            if (f.word == ARM_WORD)        c = CMD_ARM;
            else if (f.word == RAISE_WORD) c = CMD_RAISE;
            else if (f.word == CLEAR_WORD) c = CMD_CLEAR;
        end
        return c;
    endfunction

endpackage

// File: rtl/trip_frame_rx.sv
module trip_frame_rx
    import trip_seq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   cs_n,
    input  logic   sck,
    input  logic   sdi,
    output logic   frame_end,
    output frame_t frame
);

    logic                  cs_q;
    logic                  sck_q;
    logic [FRAME_BITS-1:0] shreg;
    logic [CNT_W-1:0]      nbits;

    logic sck_rise;
    logic cs_fall;
    logic cs_rise;

    always_comb begin
        sck_rise = sck & ~sck_q & ~cs_n;
        cs_fall  = ~cs_n & cs_q;
        cs_rise  = cs_n & ~cs_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_q      <= 1'b1;
            sck_q     <= 1'b0;
            shreg     <= '0;
            nbits     <= '0;
            frame_end <= 1'b0;
            frame     <= '0;
        end else begin
            cs_q      <= cs_n;
            sck_q     <= sck;
            frame_end <= cs_rise;
            if (cs_fall) begin
                shreg <= '0;
                nbits <= '0;
            end else if (sck_rise) begin
                shreg <= {shreg[FRAME_BITS-2:0], sdi};
                if (nbits != CNT_SAT) nbits <= nbits + 1'b1;
            end
            if (cs_rise) begin
                frame.word   <= shreg;
                frame.len_ok <= (nbits == CNT_FULL);
            end
        end
    end

endmodule

// File: rtl/trip_seq_fsm.sv
module trip_seq_fsm
    import trip_seq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   frame_end,
    input  frame_t frame,
    input  logic   prog_en,
    input  logic   lock,
    output logic   raise_stb,
    output logic   clear_stb
);

    seq_state_e state;
    cmd_e       cmd;

    always_comb cmd = classify(frame);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= SQ_IDLE;
            raise_stb <= 1'b0;
            clear_stb <= 1'b0;
        end else begin
            raise_stb <= 1'b0;
            clear_stb <= 1'b0;
            if (!prog_en) begin
                state <= SQ_IDLE;
            end else if (frame_end) begin
                if (lock) begin
                    state <= SQ_IDLE;
                end else begin
                    case (state)
                        SQ_IDLE:  state <= (cmd == CMD_ARM) ? SQ_ARMED : SQ_IDLE;
                        SQ_ARMED: begin
                            state     <= SQ_IDLE;
                            raise_stb <= (cmd == CMD_RAISE);
                            clear_stb <= (cmd == CMD_CLEAR);
                        end
                        default:  state <= SQ_IDLE;
                    endcase
                end
            end
        end
    end

endmodule

// File: rtl/trip_prog_timer.sv
module trip_prog_timer
    import trip_seq_pkg::*;
#(
    parameter int BUSY_TICKS  = 10,
    parameter int RECOV_TICKS = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic tick,
    output logic busy,
    output logic lock
);

    localparam int MAXT  = (BUSY_TICKS > RECOV_TICKS) ? BUSY_TICKS : RECOV_TICKS;
    localparam int TCW   = $clog2(MAXT + 1);
    localparam logic [TCW-1:0] BUSY_LAST  = TCW'(BUSY_TICKS - 1);
    localparam logic [TCW-1:0] RECOV_LAST = TCW'(RECOV_TICKS - 1);

    tmr_state_e     state;
    logic [TCW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= TM_IDLE;
            cnt   <= '0;
        end else begin
            case (state)
                TM_IDLE: if (start) begin
                    state <= TM_BUSY;
                    cnt   <= '0;
                end
                TM_BUSY: if (tick) begin
                    if (cnt == BUSY_LAST) begin
                        state <= TM_RECOV;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                TM_RECOV: if (tick) begin
                    if (cnt == RECOV_LAST) begin
                        state <= TM_IDLE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= TM_IDLE;
            endcase
        end
    end

    always_comb begin
        busy = (state == TM_BUSY);
        lock = (state != TM_IDLE);
    end

endmodule

// File: rtl/trip_prog_detect.sv
module trip_prog_detect
    import trip_seq_pkg::*;
#(
    parameter int BUSY_TICKS  = 10,
    parameter int RECOV_TICKS = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic cs_n,
    input  logic sck,
    input  logic sdi,
    input  logic prog_en,
    input  logic tick,
    output logic thr_raise,
    output logic thr_clear,
    output logic busy
);

    logic   frame_end;
    frame_t frame;
    logic   lock;

    trip_frame_rx i_rx (
        .clk       (clk),
        .rst       (rst),
        .cs_n      (cs_n),
        .sck       (sck),
        .sdi       (sdi),
        .frame_end (frame_end),
        .frame     (frame)
    );

    trip_seq_fsm i_fsm (
        .clk       (clk),
        .rst       (rst),
        .frame_end (frame_end),
        .frame     (frame),
        .prog_en   (prog_en),
        .lock      (lock),
        .raise_stb (thr_raise),
        .clear_stb (thr_clear)
    );

    trip_prog_timer #(
        .BUSY_TICKS  (BUSY_TICKS),
        .RECOV_TICKS (RECOV_TICKS)
    ) i_tmr (
        .clk   (clk),
        .rst   (rst),
        .start (thr_raise | thr_clear),
        .tick  (tick),
        .busy  (busy),
        .lock  (lock)
    );

endmodule

// File: rtl/trip_prog_detect_chk.sv
module trip_prog_detect_chk (
    input logic clk,
    input logic rst,
    input logic cs_n,
    input logic prog_en,
    input logic thr_raise,
    input logic thr_clear,
    input logic busy
);

    // R7
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(thr_raise && thr_clear));

    // R7
    raise_width_chk: assert property (@(posedge clk) disable iff (rst)
        thr_raise |=> !thr_raise);

    // R7
    clear_width_chk: assert property (@(posedge clk) disable iff (rst)
        thr_clear |=> !thr_clear);

    // R6
    strobe_en_chk: assert property (@(posedge clk) disable iff (rst)
        (thr_raise || thr_clear) |-> $past(prog_en));

    // R2
    strobe_cs_chk: assert property (@(posedge clk) disable iff (rst)
        (thr_raise || thr_clear) |-> $past(cs_n, 2));

    // R8
    busy_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (thr_raise || thr_clear) |=> busy);

    // R9
    strobe_unlocked_chk: assert property (@(posedge clk) disable iff (rst)
        (thr_raise || thr_clear) |-> !busy);

endmodule

bind trip_prog_detect trip_prog_detect_chk i_chk (
    .clk       (clk),
    .rst       (rst),
    .cs_n      (cs_n),
    .prog_en   (prog_en),
    .thr_raise (thr_raise),
    .thr_clear (thr_clear),
    .busy      (busy)
);

// File: tb/test_trip_prog_detect.sv
module test_trip_prog_detect;

    localparam int BUSY_T  = 10;
    localparam int RECOV_T = 10;
    localparam int TICK_P  = 64;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n = 1'b1;
    logic sck = 1'b0;
    logic sdi = 1'b0;
    logic prog_en = 1'b0;
    logic tick = 1'b0;
    logic thr_raise;
    logic thr_clear;
    logic busy;

    int n_checks = 0;
    int n_fail = 0;
    int n_raise = 0;
    int n_clear = 0;
    int busy_ticks = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    trip_prog_detect #(.BUSY_TICKS(BUSY_T), .RECOV_TICKS(RECOV_T)) i_trip_prog_detect (
        .clk (clk), .rst (rst), .cs_n (cs_n), .sck (sck), .sdi (sdi),
        .prog_en (prog_en), .tick (tick),
        .thr_raise (thr_raise), .thr_clear (thr_clear), .busy (busy)
    );

    typedef struct packed {
        logic [31:0] w1;
        logic [7:0]  n1;
        logic [31:0] w2;
        logic [7:0]  n2;
        logic        en;
        logic        er;
        logic        ec;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{32'h030001, 8'd24, 32'h020001, 8'd24, 1'b1, 1'b1, 1'b0}, // R2
        '{32'h030001, 8'd24, 32'h020003, 8'd24, 1'b1, 1'b0, 1'b1}, // R3
        '{32'h030001, 8'd24, 32'h020002, 8'd24, 1'b1, 1'b0, 1'b0}, // R5
        '{32'h020001, 8'd24, 32'h020001, 8'd24, 1'b1, 1'b0, 1'b0}, // R5
        '{32'h030001, 8'd23, 32'h020001, 8'd24, 1'b1, 1'b0, 1'b0}, // R4
        '{32'h030001, 8'd24, 32'h020001, 8'd25, 1'b1, 1'b0, 1'b0}, // R4
        '{32'h030001, 8'd24, 32'h020001, 8'd24, 1'b0, 1'b0, 1'b0}, // R6
        '{32'h030101, 8'd24, 32'h020001, 8'd24, 1'b1, 1'b0, 1'b0}, // R5
        '{32'h040001, 8'd24, 32'h020003, 8'd24, 1'b1, 1'b0, 1'b0}, // R5
        '{32'h030001, 8'd24, 32'h020003, 8'd24, 1'b1, 1'b0, 1'b1}  // R3
    };

    function automatic string vec_req(input int i);
        case (i)
            0:       return "R2";
            1, 9:    return "R3";
            4, 5:    return "R4";
            6:       return "R6";
            default: return "R5";
        endcase
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic send_frame(input logic [31:0] w, input int n);
        @(negedge clk) cs_n = 1'b0;
        repeat (2) @(negedge clk);
        for (int i = n - 1; i >= 0; i--) begin
            sdi = w[i];
            repeat (2) @(negedge clk);
            sck = 1'b1;
            repeat (2) @(negedge clk);
            sck = 1'b0;
        end
        repeat (2) @(negedge clk);
        cs_n = 1'b1;
    endtask

    // strobe monitor
    initial begin
        forever begin
            @(negedge clk);
            if (thr_raise) n_raise++;
            if (thr_clear) n_clear++;
        end
    end

    // timebase and busy tick counter
    initial begin
        forever begin
            repeat (TICK_P - 1) @(negedge clk);
            tick = 1'b1;
            if (busy) busy_ticks++;
            @(negedge clk);
            tick = 1'b0;
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int r0, c0;
        repeat (4) @(negedge clk);
        // R1 reset state
        check("R1", "raise after reset", thr_raise, 0);
        check("R1", "clear after reset", thr_clear, 0);
        check("R1", "busy after reset", busy, 0);
        rst = 1'b0;
        repeat (4) @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            prog_en = VECS[v].en;
            r0 = n_raise;
            c0 = n_clear;
            send_frame(VECS[v].w1, int'(VECS[v].n1));
            repeat (4) @(negedge clk);
            send_frame(VECS[v].w2, int'(VECS[v].n2));
            repeat (6) @(negedge clk);
            check(vec_req(v), $sformatf("vector %0d raise count", v), n_raise - r0, int'(VECS[v].er));
            check(vec_req(v), $sformatf("vector %0d clear count", v), n_clear - c0, int'(VECS[v].ec));
            repeat ((BUSY_T + RECOV_T + 2) * TICK_P) @(negedge clk);
        end

        // R2 / R7 / R8: exact strobe cycle and busy width
        prog_en = 1'b1;
        send_frame(32'h030001, 24);
        repeat (4) @(negedge clk);
        busy_ticks = 0;
        send_frame(32'h020001, 24);
        @(negedge clk);
        check("R2", "raise one edge after cs high", thr_raise, 0);
        @(negedge clk);
        check("R2", "raise two edges after cs high", thr_raise, 1);
        check("R7", "clear during raise", thr_clear, 0);
        @(negedge clk);
        check("R7", "raise width", thr_raise, 0);
        check("R8", "busy after strobe", busy, 1);
        while (busy) @(negedge clk);
        check("R8", "ticks seen while busy", busy_ticks, BUSY_T);

        // R9: command inside recovery is ignored
        r0 = n_raise;
        send_frame(32'h030001, 24);
        repeat (4) @(negedge clk);
        send_frame(32'h020001, 24);
        repeat (6) @(negedge clk);
        check("R9", "raise during recovery", n_raise - r0, 0);
        check("R9", "busy after ignored command", busy, 0);
        repeat ((RECOV_T + 2) * TICK_P) @(negedge clk);
        r0 = n_raise;
        send_frame(32'h030001, 24);
        repeat (4) @(negedge clk);
        send_frame(32'h020001, 24);
        repeat (6) @(negedge clk);
        check("R9", "raise after recovery", n_raise - r0, 1);
        repeat ((BUSY_T + RECOV_T + 2) * TICK_P) @(negedge clk);

        // R6: enable drop between frames cancels
        r0 = n_raise;
        c0 = n_clear;
        send_frame(32'h030001, 24);
        repeat (2) @(negedge clk);
        prog_en = 1'b0;
        repeat (2) @(negedge clk);
        prog_en = 1'b1;
        repeat (2) @(negedge clk);
        send_frame(32'h020003, 24);
        repeat (6) @(negedge clk);
        check("R6", "clear after enable drop", n_clear - c0, 0);
        check("R6", "raise after enable drop", n_raise - r0, 0);

        // R5: a wrong second frame leaves the detector idle, not armed
        send_frame(32'h030001, 24);
        repeat (4) @(negedge clk);
        send_frame(32'h020005, 24);
        repeat (4) @(negedge clk);
        send_frame(32'h020001, 24);
        repeat (6) @(negedge clk);
        check("R5", "raise after broken pair", n_raise - r0, 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule